// File: doc/BRIEF.md
# Skip-Symbol Elastic Rate Matcher

This block is a small dual-clock elastic buffer. It sits between a receive path clocked by a recovered clock and logic clocked by a local clock of nearly the same frequency. Symbols arrive on the write side already decoded, aligned and deskewed, as 9-bit values: bit 8 is the control flag and bits 7:0 are the byte. The read side produces one symbol on every local clock cycle.

Because the two clocks drift apart slowly, the buffer would fill up or drain over time. To keep the fill level near the middle, the block uses the padding symbols found in skip ordered sets. A skip ordered set is a K28.5 comma (9'h1BC) followed by one or more K28.0 skips (9'h11C).
- When the buffer is too full, the write side drops one skip from a run of skips.
- When the buffer is too empty, the read side sends one skip a second time.

If the buffer still fills completely, incoming symbols are discarded. If it runs dry, the output carries the K30.7 filler (9'h1FE). In both cases the buffer recovers on its own, without a reset. Each of these four events produces a one-cycle pulse in the clock domain where it happens.

Top module: `skip_rate_matcher`

## Requirements
- R1: During reset the read output holds the filler 9'h1FE. All four event pulses are low.
- R2: Every written symbol that is neither deleted nor dropped appears on `rd_sym` unchanged and in order. The encoding is bit 8 = control flag and bits 7:0 = byte.
- R3: A deletion removes only a K28.0 (9'h11C) that directly follows another K28.0 in the write stream. It happens only when the write-side fill count is above the upper watermark (12 by default). `wr_del_pulse` rises one write clock after the edge that takes the removed symbol.
- R4: At most one skip is removed from any single run of consecutive K28.0 symbols.
- R5: An insertion repeats a K28.0 that was output in the previous cycle. It happens only while the read-side fill count is below the lower watermark (4 by default). `rd_ins_pulse` is high in the same cycle as the repeated symbol. At most one skip is added per run.
- R6: When the buffer is full, a valid input symbol is discarded and `wr_ovf_pulse` rises one write clock later. A pulse never comes from an idle cycle, and a deletion and a discard never happen for the same symbol.
- R7: When the buffer is empty and no insertion applies, `rd_sym` carries 9'h1FE and `rd_unf_pulse` is high in the same cycle.
- R8: After an overflow or an underflow, the stream continues intact without any reset. Once writing stops, every queued symbol is eventually delivered.
- R9: Skip runs of any length are handled. Runs of 1 to 8 skips pass without loss of the surrounding data.
- R10: With a skip ordered set at least every 32 symbols, the buffer absorbs a rate offset of ±300 PPM (600 PPM in total). Once traffic is flowing, it neither overflows while the reader is slower nor underflows while the reader is faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_valid | input | 1 | `wr_sym` holds a symbol this cycle |
| wr_sym | input | 9 | Input symbol: bit 8 is the control flag, bits 7:0 are the byte |
| wr_del_pulse | output | 1 | A skip was removed on the write side |
| wr_ovf_pulse | output | 1 | A symbol was discarded because the buffer was full |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_sym | output | 9 | Output symbol, one per read clock |
| rd_ins_pulse | output | 1 | `rd_sym` is a repeated skip |
| rd_unf_pulse | output | 1 | `rd_sym` is the underflow filler |

## Verification
Each write-side pulse is registered, so it belongs to the symbol taken at the previous write edge. The bench drives inputs on falling write edges. Before driving the next symbol, it reads the pulses that belong to the one just taken.

Read-side pulses change on the same rising read edge as `rd_sym`, so the bench samples both together on the following falling edge. A written symbol can appear at the output no sooner than three read edges later: two synchronizer stages plus the output register. Because of this, expected symbols are queued on the write side well before the read-side checker pops them.

The checks work on whole streams and run-tracking state that the bench computes itself. They do not depend on exact synchronizer latency.

// File: rtl/rm_pkg.sv
// Shared symbol type and the special symbol codes of the rate matcher.
package rm_pkg;
    localparam int SYM_W = 9;
    typedef logic [SYM_W-1:0] sym_t;
    localparam sym_t K_COMMA = 9'h1BC;   // K28.5, opens a skip ordered set
    localparam sym_t K_SKIP  = 9'h11C;   // K28.0, removable/insertable padding
    localparam sym_t K_FILL  = 9'h1FE;   // K30.7, underflow filler
endpackage

// File: rtl/rm_ptr_cnt.sv
// Binary pointer with a registered Gray copy for crossing clock domains.
// Assumes the Gray output is sampled only by a synchronizer in the other domain.
module rm_ptr_cnt #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);
    logic [PW-1:0] bin_nx;

    // next binary value
    always_comb bin_nx = bin + PW'(inc);

    // hold pointer and its Gray image, both updated on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/rm_sync_bin.sv
// Two-flop synchronizer for a Gray pointer, followed by Gray-to-binary decode.
// Assumes the source changes at most one bit per source clock.
module rm_sync_bin #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta;
    logic [PW-1:0] stable;

    // two-stage capture into the local domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            stable <= '0;
        end else begin
            meta   <= gray_in;
            stable <= meta;
        end
    end

    // each binary bit is the XOR of all Gray bits at or above it
    for (genvar i = 0; i < PW; i++) begin : g_dec
        assign bin_out[i] = ^stable[PW-1:i];
    end
endmodule

// File: rtl/rm_dpram.sv
// Storage array: synchronous write in the write domain, combinational read.
// Assumes the controllers never read an entry that is being written.
module rm_dpram #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // store one entry per enabled write
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rm_write_side.sv
// Write-domain control. It tracks skip runs, removes one skip per run when the
// fill count is above the upper watermark, and discards input while full.
// Assumes rd_gray comes from the read pointer's registered Gray copy.
module rm_write_side
    import rm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int HI_WM = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  sym_t                     sym,
    input  logic [$clog2(DEPTH):0]   rd_gray,
    output logic [$clog2(DEPTH):0]   wr_gray,
    output logic                     we,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output logic                     del_pulse,
    output logic                     ovf_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HI_LIM = PW'(HI_WM);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill;
    logic          prev_skip;
    logic          del_done;
    logic          is_skip;
    logic          do_del;
    logic          full;

    rm_ptr_cnt #(.PW(PW)) u_wptr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (we),
        .bin  (wbin),
        .gray (wr_gray)
    );

    rm_sync_bin #(.PW(PW)) u_rsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_in(rd_gray),
        .bin_out(rbin_s)
    );

    // fill seen from the write side (pessimistic: read pointer lags)
    always_comb begin
        fill    = wbin - rbin_s;
        full    = (fill == FULL_V);
        is_skip = (sym == K_SKIP);
        do_del  = valid && is_skip && prev_skip && !del_done && (fill > HI_LIM);
        we      = valid && !do_del && !full;
        waddr   = wbin[AW-1:0];
    end

    // run tracking and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_skip <= 1'b0;
            del_done  <= 1'b0;
            del_pulse <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            del_pulse <= do_del;
            ovf_pulse <= valid && !do_del && full;
            if (valid) begin
                prev_skip <= is_skip;
                if (!is_skip)    del_done <= 1'b0;
                else if (do_del) del_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rm_read_side.sv
// Read-domain control. It sends one symbol per cycle, repeats one skip per run
// when the fill count is below the lower watermark, and sends the filler when
// the buffer is empty.
// Assumes rdata is the entry at raddr in the same cycle.
module rm_read_side
    import rm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LO_WM = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH):0]   wr_gray,
    input  sym_t                     rdata,
    output logic [$clog2(DEPTH):0]   rd_gray,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output sym_t                     out_sym,
    output logic                     ins_pulse,
    output logic                     unf_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] LO_LIM = PW'(LO_WM);

    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] fill;
    logic          last_skip;
    logic          ins_done;
    logic          do_ins;
    logic          do_pop;
    logic          empty;

    rm_ptr_cnt #(.PW(PW)) u_rptr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (do_pop),
        .bin  (rbin),
        .gray (rd_gray)
    );

    rm_sync_bin #(.PW(PW)) u_wsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .gray_in(wr_gray),
        .bin_out(wbin_s)
    );

    // fill seen from the read side and this cycle's choice
    always_comb begin
        fill   = wbin_s - rbin;
        empty  = (fill == '0);
        do_ins = last_skip && !ins_done && (fill < LO_LIM);
        do_pop = !do_ins && !empty;
        raddr  = rbin[AW-1:0];
    end

    // output register, run tracking and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sym   <= K_FILL;
            last_skip <= 1'b0;
            ins_done  <= 1'b0;
            ins_pulse <= 1'b0;
            unf_pulse <= 1'b0;
        end else begin
            ins_pulse <= do_ins;
            unf_pulse <= !do_ins && empty;
            if (do_ins) begin
                out_sym  <= K_SKIP;
                ins_done <= 1'b1;
            end else if (do_pop) begin
                out_sym   <= rdata;
                last_skip <= (rdata == K_SKIP);
                if (rdata != K_SKIP) ins_done <= 1'b0;
            end else begin
                out_sym   <= K_FILL;
                last_skip <= 1'b0;
                ins_done  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/skip_rate_matcher.sv
// Top of the skip-based elastic rate matcher. It connects the write control,
// the read control and the storage array, and exchanges pointers as Gray code.
// Assumes DEPTH is a power of two and LO_WM < HI_WM < DEPTH.
module skip_rate_matcher
    import rm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int HI_WM = 12,
    parameter int LO_WM = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_valid,
    input  logic [8:0] wr_sym,
    output logic       wr_del_pulse,
    output logic       wr_ovf_pulse,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    output logic [8:0] rd_sym,
    output logic       rd_ins_pulse,
    output logic       rd_unf_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    sym_t          rdata;

    rm_write_side #(.DEPTH(DEPTH), .HI_WM(HI_WM)) u_wr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .valid    (wr_valid),
        .sym      (wr_sym),
        .rd_gray  (rd_gray),
        .wr_gray  (wr_gray),
        .we       (we),
        .waddr    (waddr),
        .del_pulse(wr_del_pulse),
        .ovf_pulse(wr_ovf_pulse)
    );

    rm_dpram #(.AW(AW), .DW(SYM_W)) u_mem (
        .wr_clk(wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_sym),
        .raddr (raddr),
        .rdata (rdata)
    );

    rm_read_side #(.DEPTH(DEPTH), .LO_WM(LO_WM)) u_rd (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .wr_gray  (wr_gray),
        .rdata    (rdata),
        .rd_gray  (rd_gray),
        .raddr    (raddr),
        .out_sym  (rd_sym),
        .ins_pulse(rd_ins_pulse),
        .unf_pulse(rd_unf_pulse)
    );
endmodule

// File: rtl/rm_checker.sv
// Port-level properties of the rate matcher, attached by bind.
module rm_checker
    import rm_pkg::*;
(
    input logic       wr_clk,
    input logic       wr_rst_n,
    input logic       wr_valid,
    input logic [8:0] wr_sym,
    input logic       wr_del_pulse,
    input logic       wr_ovf_pulse,
    input logic       rd_clk,
    input logic       rd_rst_n,
    input logic [8:0] rd_sym,
    input logic       rd_ins_pulse,
    input logic       rd_unf_pulse
);
    assert_rd_reset_R1: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (rd_sym == K_FILL && !rd_ins_pulse && !rd_unf_pulse));

    assert_wr_reset_R1: assert property (@(posedge wr_clk)
        !wr_rst_n |=> (!wr_del_pulse && !wr_ovf_pulse));

    assert_del_only_skip_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_valid && wr_sym != K_SKIP) |=> !wr_del_pulse);

    assert_one_del_per_run_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_del_pulse |=> !wr_del_pulse);

    assert_ins_repeats_skip_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_ins_pulse |-> (rd_sym == K_SKIP && $past(rd_sym) == K_SKIP));

    assert_one_ins_per_run_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_ins_pulse |=> !rd_ins_pulse);

    assert_no_pulse_idle_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_valid |=> (!wr_del_pulse && !wr_ovf_pulse));

    assert_del_ovf_exclusive_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !(wr_del_pulse && wr_ovf_pulse));

    assert_fill_on_underflow_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_unf_pulse |-> (rd_sym == K_FILL && !rd_ins_pulse));
endmodule

bind skip_rate_matcher rm_checker i_rm_checker (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .wr_valid    (wr_valid),
    .wr_sym      (wr_sym),
    .wr_del_pulse(wr_del_pulse),
    .wr_ovf_pulse(wr_ovf_pulse),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_sym      (rd_sym),
    .rd_ins_pulse(rd_ins_pulse),
    .rd_unf_pulse(rd_unf_pulse)
);

// File: tb/test_skip_rate_matcher.sv
`timescale 1ns/1ps
module test_skip_rate_matcher;
    import rm_pkg::*;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_sym = '0;
    logic       wr_del_pulse, wr_ovf_pulse;
    logic [8:0] rd_sym;
    logic       rd_ins_pulse, rd_unf_pulse;

    realtime rd_half = 4.0;

    always #4 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    skip_rate_matcher i_skip_rate_matcher (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_sym(wr_sym),
        .wr_del_pulse(wr_del_pulse), .wr_ovf_pulse(wr_ovf_pulse),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sym(rd_sym),
        .rd_ins_pulse(rd_ins_pulse), .rd_unf_pulse(rd_unf_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    int del_cnt = 0, ovf_cnt = 0, ins_cnt = 0, unf_cnt = 0;
    logic [8:0] exp_q[$];
    bit   mon_on = 0;

    // write-side bookkeeping of the previously driven symbol
    bit   pv = 0;
    sym_t ps = '0;
    bit   in_prev_skip = 0;
    bit   in_del_done = 0;
    // read-side run tracking
    bit   o_last_skip = 0;
    bit   o_ins_done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // a removal is legal only for a skip that follows a skip, once per run
    function automatic bit del_legal(input sym_t s, input bit prev_skip, input bit done);
        return (s == K_SKIP) && prev_skip && !done;
    endfunction

    // a repeat is legal only right after an output skip, once per run
    function automatic bit ins_legal(input sym_t s, input bit last_skip, input bit done);
        return (s == K_SKIP) && last_skip && !done;
    endfunction

    function automatic sym_t rand_data();
        return {1'b0, 8'($urandom)};
    endfunction

    // account for the symbol taken at the previous write edge
    task automatic account();
        if (pv) begin
            chk(!(wr_del_pulse && wr_ovf_pulse), "R6", "delete and discard together",
                {wr_del_pulse, wr_ovf_pulse}, 0);
            if (wr_del_pulse) begin
                chk(ps == K_SKIP && in_prev_skip, "R3", "removed symbol", ps, K_SKIP);
                chk(del_legal(ps, in_prev_skip, in_del_done), "R4",
                    "second removal in one run", 1, 0);
                del_cnt++;
                in_del_done = 1;
            end else if (wr_ovf_pulse) begin
                ovf_cnt++;
            end else begin
                exp_q.push_back(ps);
            end
            in_prev_skip = (ps == K_SKIP);
            if (ps != K_SKIP) in_del_done = 0;
        end else begin
            chk(!wr_del_pulse && !wr_ovf_pulse, "R6", "pulse on idle cycle",
                {wr_del_pulse, wr_ovf_pulse}, 0);
        end
    endtask

    task automatic wr_step(input bit v, input sym_t s);
        @(negedge wr_clk);
        account();
        wr_valid = v;
        wr_sym   = s;
        pv = v;
        ps = s;
    endtask

    // R9: skip runs of varied length inside ordered sets
    task automatic send_set(input int nskip);
        wr_step(1, K_COMMA);
        for (int k = 0; k < nskip; k++) wr_step(1, K_SKIP);
    endtask

    task automatic stream(input int nsym, input bit with_sets);
        int gap = 10 + int'($urandom % 14);
        for (int i = 0; i < nsym; i++) begin
            if (with_sets && gap == 0) begin
                send_set(1 + int'($urandom % 8));
                gap = 10 + int'($urandom % 14);
            end else begin
                wr_step(1, rand_data());
                gap--;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) wr_step(0, '0);
    endtask

    // read-side checker: pulses and data sampled together on falling edges
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (rd_unf_pulse) begin
                chk(rd_sym == K_FILL, "R7", "underflow symbol", rd_sym, K_FILL);
                unf_cnt++;
                o_last_skip = 0;
                o_ins_done  = 0;
            end else if (rd_ins_pulse) begin
                chk(ins_legal(rd_sym, o_last_skip, o_ins_done), "R5",
                    "illegal repeat", rd_sym, K_SKIP);
                ins_cnt++;
                o_ins_done = 1;
            end else begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "output with nothing queued", rd_sym, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(rd_sym == e, "R2", "output symbol", rd_sym, e);
                end
                o_last_skip = (rd_sym == K_SKIP);
                if (rd_sym != K_SKIP) o_ins_done = 0;
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (6) @(negedge rd_clk);
        // R1: reset state
        chk(rd_sym == K_FILL, "R1", "reset output", rd_sym, K_FILL);
        chk(!rd_ins_pulse && !rd_unf_pulse, "R1", "read pulses in reset",
            {rd_ins_pulse, rd_unf_pulse}, 0);
        chk(!wr_del_pulse && !wr_ovf_pulse, "R1", "write pulses in reset",
            {wr_del_pulse, wr_ovf_pulse}, 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        @(posedge rd_clk);
        mon_on = 1;

        // phase A: slower reader (0.5 %), removals must occur, no overflow (R10, R3)
        rd_half = 4.02;
        stream(500, 1);
        del_cnt = 0; ovf_cnt = 0;
        stream(6000, 1);
        chk(ovf_cnt == 0, "R10", "overflow with slower reader", ovf_cnt, 0);
        chk(del_cnt > 0, "R3", "removals with slower reader", del_cnt, 1);

        // phase B: faster reader (0.5 %), repeats must occur, no underflow (R10, R5)
        rd_half = 3.98;
        stream(1000, 1);
        ins_cnt = 0; unf_cnt = 0;
        stream(6000, 1);
        chk(unf_cnt == 0, "R10", "underflow with faster reader", unf_cnt, 0);
        chk(ins_cnt > 0, "R5", "repeats with faster reader", ins_cnt, 1);

        // phase C: reader at half rate, no skips: discards must occur (R6)
        rd_half = 8.0;
        ovf_cnt = 0;
        stream(300, 0);
        chk(ovf_cnt > 0, "R6", "discards while full", ovf_cnt, 1);

        // phase D: writer idle: filler must appear (R7)
        rd_half = 4.0;
        unf_cnt = 0;
        idle(300);
        chk(unf_cnt > 0, "R7", "filler while empty", unf_cnt, 1);

        // R8: recovery without reset, then full drain
        stream(400, 1);
        idle(200);
        chk(exp_q.size() == 0, "R8", "symbols left undelivered", exp_q.size(), 0);
        repeat (4) @(negedge rd_clk);
        chk(rd_sym == K_FILL && rd_unf_pulse, "R7", "idle output after drain", rd_sym, K_FILL);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule